// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block keeps the squash state of every hardware thread at the retire end of an out-of-order core. Each thread can be flushed by three kinds of request: a squash that the execute stage reports with a sequence number, a whole-thread flush that a write to the thread's architectural context asks for, and a whole-thread flush that follows a taken fault once a fixed trap delay has run out. The block decides which request takes effect in a cycle. It then sends a one-cycle squash bundle back to the front of the pipe. The bundle holds the sequence number to squash to, a squash strobe, the reorder-buffer-squashing flag, the mispredict and taken flags, and the redirect PC.

For each thread the block tracks one of four states: idle, running, reorder-buffer squashing, and trap pending. It also tracks the youngest sequence number that is still valid for the thread. An execute-stage squash that is younger than the youngest valid sequence number is dropped, so an older squash cannot be overridden by a younger one. The reorder buffer storage and the PC datapath sit outside the block. They supply the head sequence number, the empty flag, the squash-done flag and the current commit PC as inputs.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset every thread is idle (state code 0). All bundle outputs are 0, youngest_seq is 0 and mispred_count is 0. An idle thread moves to running (code 1) on the clock edge where its thread_active bit is 1.
- R2: A fault_take on a running thread with no trap in flight moves it to trap pending (code 3) at that edge. The whole-thread squash bundle then appears exactly TRAP_CYCLES+1 edges after the fault edge, and not earlier.
- R3: An execute-stage squash that arrives while its thread is in trap pending has no effect. No bundle is driven and the state stays at code 3.
- R4: An execute-stage squash takes effect only if its sequence number is less than or equal to the thread's youngest valid sequence number. Equality is accepted. A younger one changes neither the state, youngest_seq nor the outputs.
- R5: An accepted execute-stage squash drives, for one cycle, sq_valid=1 and sq_rob_squashing=1. The sequence number it drives is the reported number, minus one (modulo 2^SEQ_W) when exe_incl_inst is 1. It also drives the request's mispredict flag, taken flag and redirect PC. It moves the thread to reorder-buffer squashing (code 2) and sets youngest_seq to the squash point.
- R6: A trap or context-write squash flushes the whole thread. Its squash point is 0 when rob_empty is 1, and otherwise rob_head_seq minus one. It sets youngest_seq to 0, drives sq_mispred=0 and sq_taken=0, takes sq_pc from commit_pc and moves the thread to code 2. A context-write request is only legal while no trap is in flight or pending for that thread.
- R7: In code 2, sq_rob_squashing stays 1 on every cycle until rob_squash_done is seen. The thread then returns to running and sq_rob_squashing goes to 0. sq_valid is high for only the one cycle of the accepted squash.
- R8: mispred_count goes up by one for each accepted execute-stage squash whose exe_mispred bit is 1, summed over threads. It does not change otherwise.
- R9: dispatch_vld loads youngest_seq with dispatch_seq, unless a squash is accepted for that thread in the same cycle. In that case the squash point wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NT | Releases an idle thread to running |
| fault_take | input | NT | Fault taken at the head of the thread |
| ctx_squash_req | input | NT | Whole-thread flush from a context write |
| exe_squash_vld | input | NT | Execute-stage squash request |
| exe_squash_seq | input | NT x SEQ_W | Sequence number of the squashing instruction |
| exe_incl_inst | input | NT | Squash the reporting instruction too |
| exe_mispred | input | NT | Request comes from a branch mispredict |
| exe_taken | input | NT | Branch taken flag of the request |
| exe_redirect_pc | input | NT x PC_W | Redirect PC of the request |
| dispatch_vld | input | NT | New youngest instruction entered the buffer |
| dispatch_seq | input | NT x SEQ_W | Its sequence number |
| rob_empty | input | NT | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NT x SEQ_W | Sequence number at the buffer head |
| rob_squash_done | input | NT | Reorder buffer finished squashing |
| commit_pc | input | NT x PC_W | Current commit PC, used for whole-thread flushes |
| sq_valid | output | NT | Squash strobe, one cycle per accepted squash |
| sq_rob_squashing | output | NT | Reorder buffer is squashing |
| sq_seq | output | NT x SEQ_W | Squash point sequence number |
| sq_mispred | output | NT | Mispredict flag of the bundle |
| sq_taken | output | NT | Taken flag of the bundle |
| sq_pc | output | NT x PC_W | Redirect PC of the bundle |
| thread_state | output | NT x 2 | 0 idle, 1 running, 2 squashing, 3 trap pending |
| youngest_seq | output | NT x SEQ_W | Youngest valid sequence number |
| mispred_count | output | CNT_W | Accepted mispredict squashes |

## Verification
The bench builds the block with two threads, 8-bit sequence numbers, 16-bit PCs and a trap delay of three cycles. The short delay lets the bench check the exact release edge of a trap flush, and it leaves room to probe the trap-pending filter on an execute squash on the way. Two threads let the bench show that the mispredict count sums over threads and that one thread's squash leaves the other's bundle quiet. The equal-sequence case and the same-cycle dispatch-and-squash case probe the age filter at its boundary.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_RUN   = 2'd1,
    TS_ROBSQ = 2'd2,
    TS_TRAP  = 2'd3
  } tstate_e;
endpackage

// File: rtl/csq_trap_timer.sv
module csq_trap_timer #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic in_flight,
  output logic pend
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      in_flight <= 1'b0;
      pend      <= 1'b0;
    end else begin
      if (clear) pend <= 1'b0;
      if (start) begin
        in_flight <= 1'b1;
        cnt_q     <= CW'(LAT);
      end else if (in_flight) begin
        if (cnt_q == CW'(1)) begin
          in_flight <= 1'b0;
          pend      <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  AST_TRAP_FLAG_AFTER_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(in_flight)) else $error("trap flag without flight"); // R2
  AST_TRAP_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_flight && !pend) else $error("trap restarted while active"); // R2
endmodule

// File: rtl/csq_arbiter.sv
module csq_arbiter
  import csq_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16
) (
  input  tstate_e            state_q,
  input  logic [SEQ_W-1:0]   youngest_q,
  input  logic               thread_active,
  input  logic               trap_pend,
  input  logic               trap_in_flight,
  input  logic               ctx_req,
  input  logic               fault,
  input  logic               exe_vld,
  input  logic [SEQ_W-1:0]   exe_seq,
  input  logic               exe_incl,
  input  logic               exe_mis,
  input  logic               exe_tak,
  input  logic [PC_W-1:0]    exe_pc,
  input  logic               disp_vld,
  input  logic [SEQ_W-1:0]   disp_seq,
  input  logic               rob_empty,
  input  logic [SEQ_W-1:0]   rob_head,
  input  logic               rob_done,
  input  logic [PC_W-1:0]    commit_pc,
  output tstate_e            state_d,
  output logic [SEQ_W-1:0]   youngest_d,
  output logic               sq_d,
  output logic               robsq_d,
  output logic [SEQ_W-1:0]   seq_d,
  output logic               mis_d,
  output logic               tak_d,
  output logic [PC_W-1:0]    pc_d,
  output logic               full_fire,
  output logic               exe_fire,
  output logic               fault_fire,
  output logic               mispred_inc
);
  function automatic logic [SEQ_W-1:0] exe_point(input logic [SEQ_W-1:0] s, input logic incl);
    return incl ? s - SEQ_W'(1) : s;
  endfunction

  function automatic logic [SEQ_W-1:0] flush_point(input logic empty, input logic [SEQ_W-1:0] head);
    return empty ? '0 : head - SEQ_W'(1);
  endfunction

  function automatic logic age_ok(input logic [SEQ_W-1:0] s, input logic [SEQ_W-1:0] young);
    return s <= young;
  endfunction

  tstate_e          s0;
  tstate_e          s1;
  logic             hold;
  logic [SEQ_W-1:0] young_mid;

  always_comb begin
    s0   = state_q;
    hold = 1'b0;
    if (state_q == TS_IDLE && thread_active) s0 = TS_RUN;
    if (state_q == TS_ROBSQ) begin
      if (rob_done) s0 = TS_RUN;
      else          hold = 1'b1;
    end

    full_fire = trap_pend | ctx_req;
    s1        = s0;
    young_mid = youngest_q;
    sq_d      = 1'b0;
    robsq_d   = hold;
    seq_d     = '0;
    mis_d     = 1'b0;
    tak_d     = 1'b0;
    pc_d      = '0;

    if (full_fire) begin
      young_mid = '0;
      s1        = TS_ROBSQ;
      sq_d      = 1'b1;
      robsq_d   = 1'b1;
      seq_d     = flush_point(rob_empty, rob_head);
      pc_d      = commit_pc;
    end

    exe_fire = exe_vld && (s1 != TS_TRAP) && age_ok(exe_seq, young_mid);
    if (exe_fire) begin
      young_mid = exe_point(exe_seq, exe_incl);
      s1        = TS_ROBSQ;
      sq_d      = 1'b1;
      robsq_d   = 1'b1;
      seq_d     = exe_point(exe_seq, exe_incl);
      mis_d     = exe_mis;
      tak_d     = exe_tak;
      pc_d      = exe_pc;
    end
    mispred_inc = exe_fire && exe_mis;

    fault_fire = fault && (s1 == TS_RUN) && !trap_in_flight && !trap_pend;
    if (fault_fire) s1 = TS_TRAP;

    youngest_d = young_mid;
    if (!full_fire && !exe_fire && disp_vld) youngest_d = disp_seq;
    state_d = s1;
  end
endmodule

// File: rtl/csq_thread.sv
module csq_thread
  import csq_pkg::*;
#(
  parameter int SEQ_W   = 8,
  parameter int PC_W    = 16,
  parameter int TRAP_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thread_active,
  input  logic             fault,
  input  logic             ctx_req,
  input  logic             exe_vld,
  input  logic [SEQ_W-1:0] exe_seq,
  input  logic             exe_incl,
  input  logic             exe_mis,
  input  logic             exe_tak,
  input  logic [PC_W-1:0]  exe_pc,
  input  logic             disp_vld,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head,
  input  logic             rob_done,
  input  logic [PC_W-1:0]  commit_pc,
  output logic             sq_valid,
  output logic             sq_robsq,
  output logic [SEQ_W-1:0] sq_seq,
  output logic             sq_mis,
  output logic             sq_tak,
  output logic [PC_W-1:0]  sq_pc,
  output logic [1:0]       state_o,
  output logic [SEQ_W-1:0] youngest_o,
  output logic             mispred_inc
);
  tstate_e          state_q, state_d;
  logic [SEQ_W-1:0] youngest_q, youngest_d;
  logic             sq_d, robsq_d, mis_d, tak_d;
  logic [SEQ_W-1:0] seq_d;
  logic [PC_W-1:0]  pc_d;
  logic             trap_pend, trap_in_flight;
  logic             full_fire, exe_fire, fault_fire;

  csq_trap_timer #(.LAT(TRAP_LAT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fault_fire),
    .clear     (trap_pend),
    .in_flight (trap_in_flight),
    .pend      (trap_pend)
  );

  csq_arbiter #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_arb (
    .state_q        (state_q),
    .youngest_q     (youngest_q),
    .thread_active  (thread_active),
    .trap_pend      (trap_pend),
    .trap_in_flight (trap_in_flight),
    .ctx_req        (ctx_req),
    .fault          (fault),
    .exe_vld        (exe_vld),
    .exe_seq        (exe_seq),
    .exe_incl       (exe_incl),
    .exe_mis        (exe_mis),
    .exe_tak        (exe_tak),
    .exe_pc         (exe_pc),
    .disp_vld       (disp_vld),
    .disp_seq       (disp_seq),
    .rob_empty      (rob_empty),
    .rob_head       (rob_head),
    .rob_done       (rob_done),
    .commit_pc      (commit_pc),
    .state_d        (state_d),
    .youngest_d     (youngest_d),
    .sq_d           (sq_d),
    .robsq_d        (robsq_d),
    .seq_d          (seq_d),
    .mis_d          (mis_d),
    .tak_d          (tak_d),
    .pc_d           (pc_d),
    .full_fire      (full_fire),
    .exe_fire       (exe_fire),
    .fault_fire     (fault_fire),
    .mispred_inc    (mispred_inc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TS_IDLE;
      youngest_q <= '0;
      sq_valid   <= 1'b0;
      sq_robsq   <= 1'b0;
      sq_seq     <= '0;
      sq_mis     <= 1'b0;
      sq_tak     <= 1'b0;
      sq_pc      <= '0;
    end else begin
      state_q    <= state_d;
      youngest_q <= youngest_d;
      sq_valid   <= sq_d;
      sq_robsq   <= robsq_d;
      sq_seq     <= seq_d;
      sq_mis     <= mis_d;
      sq_tak     <= tak_d;
      sq_pc      <= pc_d;
    end
  end

  assign state_o    = state_q;
  assign youngest_o = youngest_q;

  AST_CTX_OUTSIDE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_req |-> !(trap_in_flight || trap_pend)) else $error("context squash during trap"); // R6
  AST_FLUSH_CLEARS_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
    full_fire && !exe_fire && !disp_vld |=> youngest_q == '0) else $error("youngest not cleared"); // R6
  AST_TRAP_BLOCKS_EXE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_TRAP) && !trap_pend && !ctx_req |=> !sq_valid) else $error("squash leaked in trap"); // R3
  AST_ROBSQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_ROBSQ) && !rob_done |=> sq_robsq) else $error("rob squashing dropped"); // R7
  AST_STROBE_WITH_ROBSQ: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> sq_robsq && (state_q == TS_ROBSQ)) else $error("bundle without squashing state"); // R5
  AST_FAULT_ENTERS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |=> state_q == TS_TRAP) else $error("fault did not enter trap"); // R2
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl #(
  parameter int NT        = 2,
  parameter int SEQ_W     = 8,
  parameter int PC_W      = 16,
  parameter int TRAP_CYCLES = 3,
  parameter int CNT_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NT-1:0]            thread_active,
  input  logic [NT-1:0]            fault_take,
  input  logic [NT-1:0]            ctx_squash_req,
  input  logic [NT-1:0]            exe_squash_vld,
  input  logic [NT-1:0][SEQ_W-1:0] exe_squash_seq,
  input  logic [NT-1:0]            exe_incl_inst,
  input  logic [NT-1:0]            exe_mispred,
  input  logic [NT-1:0]            exe_taken,
  input  logic [NT-1:0][PC_W-1:0]  exe_redirect_pc,
  input  logic [NT-1:0]            dispatch_vld,
  input  logic [NT-1:0][SEQ_W-1:0] dispatch_seq,
  input  logic [NT-1:0]            rob_empty,
  input  logic [NT-1:0][SEQ_W-1:0] rob_head_seq,
  input  logic [NT-1:0]            rob_squash_done,
  input  logic [NT-1:0][PC_W-1:0]  commit_pc,
  output logic [NT-1:0]            sq_valid,
  output logic [NT-1:0]            sq_rob_squashing,
  output logic [NT-1:0][SEQ_W-1:0] sq_seq,
  output logic [NT-1:0]            sq_mispred,
  output logic [NT-1:0]            sq_taken,
  output logic [NT-1:0][PC_W-1:0]  sq_pc,
  output logic [NT-1:0][1:0]       thread_state,
  output logic [NT-1:0][SEQ_W-1:0] youngest_seq,
  output logic [CNT_W-1:0]         mispred_count
);
  logic [NT-1:0]  mis_inc;
  logic [CNT_W-1:0] inc_sum;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    csq_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .TRAP_LAT(TRAP_CYCLES)) u_thr (
      .clk           (clk),
      .rst_n         (rst_n),
      .thread_active (thread_active[t]),
      .fault         (fault_take[t]),
      .ctx_req       (ctx_squash_req[t]),
      .exe_vld       (exe_squash_vld[t]),
      .exe_seq       (exe_squash_seq[t]),
      .exe_incl      (exe_incl_inst[t]),
      .exe_mis       (exe_mispred[t]),
      .exe_tak       (exe_taken[t]),
      .exe_pc        (exe_redirect_pc[t]),
      .disp_vld      (dispatch_vld[t]),
      .disp_seq      (dispatch_seq[t]),
      .rob_empty     (rob_empty[t]),
      .rob_head      (rob_head_seq[t]),
      .rob_done      (rob_squash_done[t]),
      .commit_pc     (commit_pc[t]),
      .sq_valid      (sq_valid[t]),
      .sq_robsq      (sq_rob_squashing[t]),
      .sq_seq        (sq_seq[t]),
      .sq_mis        (sq_mispred[t]),
      .sq_tak        (sq_taken[t]),
      .sq_pc         (sq_pc[t]),
      .state_o       (thread_state[t]),
      .youngest_o    (youngest_seq[t]),
      .mispred_inc   (mis_inc[t])
    );
  end

  always_comb begin
    inc_sum = '0;
    for (int t = 0; t < NT; t++) inc_sum = inc_sum + CNT_W'(mis_inc[t]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mispred_count <= '0;
    else        mispred_count <= mispred_count + inc_sum;
  end

  AST_CNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_inc == '0) |=> $stable(mispred_count)) else $error("counter moved without mispredict"); // R8
endmodule

// File: tb/commit_squash_ctrl_tb.sv
module commit_squash_ctrl_tb;
  localparam int NT = 2, SW = 8, PW = 16, CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] thread_active = '0, fault_take = '0, ctx_squash_req = '0, exe_squash_vld = '0;
  logic [NT-1:0][SW-1:0] exe_squash_seq = '0, dispatch_seq = '0, rob_head_seq = '0;
  logic [NT-1:0] exe_incl_inst = '0, exe_mispred = '0, exe_taken = '0, dispatch_vld = '0;
  logic [NT-1:0] rob_empty = '1, rob_squash_done = '0;
  logic [NT-1:0][PW-1:0] exe_redirect_pc = '0, commit_pc = '0;
  logic [NT-1:0] sq_valid, sq_rob_squashing, sq_mispred, sq_taken;
  logic [NT-1:0][SW-1:0] sq_seq, youngest_seq;
  logic [NT-1:0][PW-1:0] sq_pc;
  logic [NT-1:0][1:0] thread_state;
  logic [CW-1:0] mispred_count;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  commit_squash_ctrl #(.NT(NT), .SEQ_W(SW), .PC_W(PW), .TRAP_CYCLES(3), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thread_active(thread_active), .fault_take(fault_take),
    .ctx_squash_req(ctx_squash_req), .exe_squash_vld(exe_squash_vld),
    .exe_squash_seq(exe_squash_seq), .exe_incl_inst(exe_incl_inst),
    .exe_mispred(exe_mispred), .exe_taken(exe_taken), .exe_redirect_pc(exe_redirect_pc),
    .dispatch_vld(dispatch_vld), .dispatch_seq(dispatch_seq), .rob_empty(rob_empty),
    .rob_head_seq(rob_head_seq), .rob_squash_done(rob_squash_done), .commit_pc(commit_pc),
    .sq_valid(sq_valid), .sq_rob_squashing(sq_rob_squashing), .sq_seq(sq_seq),
    .sq_mispred(sq_mispred), .sq_taken(sq_taken), .sq_pc(sq_pc),
    .thread_state(thread_state), .youngest_seq(youngest_seq), .mispred_count(mispred_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_squash(input int t);
    rob_squash_done[t] = 1'b1;
    step();
    chk("R7 back to running", int'(thread_state[t]), 1);
    chk("R7 robsq released", int'(sq_rob_squashing[t]), 0);
    rob_squash_done[t] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state t0", int'(thread_state[0]), 0);
    chk("R1 reset state t1", int'(thread_state[1]), 0);
    chk("R1 reset strobe", int'(sq_valid), 0);
    chk("R1 reset count", int'(mispred_count), 0);
    thread_active = '1;
    step();
    chk("R1 running t0", int'(thread_state[0]), 1);
    chk("R1 running t1", int'(thread_state[1]), 1);
  endtask

  task automatic t_exe_accept();
    dispatch_vld[0] = 1'b1; dispatch_seq[0] = 8'd20;
    step();
    dispatch_vld[0] = 1'b0;
    chk("R9 dispatch youngest", int'(youngest_seq[0]), 20);
    exe_squash_vld[0] = 1'b1; exe_squash_seq[0] = 8'd15; exe_incl_inst[0] = 1'b1;
    exe_mispred[0] = 1'b1; exe_taken[0] = 1'b1; exe_redirect_pc[0] = 16'h1234;
    step();
    exe_squash_vld[0] = 1'b0; exe_incl_inst[0] = 1'b0; exe_mispred[0] = 1'b0; exe_taken[0] = 1'b0;
    chk("R5 strobe", int'(sq_valid[0]), 1);
    chk("R5 point incl", int'(sq_seq[0]), 14);
    chk("R5 mispred", int'(sq_mispred[0]), 1);
    chk("R5 taken", int'(sq_taken[0]), 1);
    chk("R5 pc", int'(sq_pc[0]), 16'h1234);
    chk("R5 state", int'(thread_state[0]), 2);
    chk("R5 youngest", int'(youngest_seq[0]), 14);
    chk("R8 count one", int'(mispred_count), 1);
    step();
    chk("R7 strobe one cycle", int'(sq_valid[0]), 0);
    chk("R7 robsq held", int'(sq_rob_squashing[0]), 1);
    finish_squash(0);
  endtask

  task automatic t_age_filter();
    exe_squash_vld[0] = 1'b1; exe_squash_seq[0] = 8'd30; exe_mispred[0] = 1'b1;
    step();
    exe_squash_vld[0] = 1'b0; exe_mispred[0] = 1'b0;
    chk("R4 younger dropped", int'(sq_valid[0]), 0);
    chk("R4 youngest kept", int'(youngest_seq[0]), 14);
    chk("R4 state kept", int'(thread_state[0]), 1);
    chk("R8 no count", int'(mispred_count), 1);
    exe_squash_vld[0] = 1'b1; exe_squash_seq[0] = 8'd14;
    step();
    exe_squash_vld[0] = 1'b0;
    chk("R4 equal accepted", int'(sq_valid[0]), 1);
    chk("R5 point no incl", int'(sq_seq[0]), 14);
    chk("R8 no mispred no count", int'(mispred_count), 1);
    finish_squash(0);
  endtask

  task automatic t_trap();
    rob_empty[0] = 1'b0; rob_head_seq[0] = 8'd10; commit_pc[0] = 16'h4000;
    fault_take[0] = 1'b1;
    step();
    fault_take[0] = 1'b0;
    chk("R2 trap pending", int'(thread_state[0]), 3);
    exe_squash_vld[0] = 1'b1; exe_squash_seq[0] = 8'd5;
    step();
    exe_squash_vld[0] = 1'b0;
    chk("R3 exe ignored", int'(sq_valid[0]), 0);
    chk("R3 state kept", int'(thread_state[0]), 3);
    chk("R3 youngest kept", int'(youngest_seq[0]), 14);
    step();
    step();
    chk("R2 not early", int'(sq_valid[0]), 0);
    step();
    chk("R2 trap flush", int'(sq_valid[0]), 1);
    chk("R6 point head-1", int'(sq_seq[0]), 9);
    chk("R6 mispred low", int'(sq_mispred[0]), 0);
    chk("R6 pc", int'(sq_pc[0]), 16'h4000);
    chk("R6 youngest zero", int'(youngest_seq[0]), 0);
    chk("R6 state", int'(thread_state[0]), 2);
    finish_squash(0);
  endtask

  task automatic t_ctx();
    rob_empty[0] = 1'b1; commit_pc[0] = 16'h5000; rob_head_seq[0] = 8'd77;
    ctx_squash_req[0] = 1'b1;
    step();
    ctx_squash_req[0] = 1'b0;
    chk("R6 ctx strobe", int'(sq_valid[0]), 1);
    chk("R6 empty point", int'(sq_seq[0]), 0);
    chk("R6 ctx pc", int'(sq_pc[0]), 16'h5000);
    chk("R6 ctx taken low", int'(sq_taken[0]), 0);
    finish_squash(0);
  endtask

  task automatic t_thread1();
    dispatch_vld[1] = 1'b1; dispatch_seq[1] = 8'd100;
    step();
    dispatch_vld[1] = 1'b0;
    chk("R9 t1 youngest", int'(youngest_seq[1]), 100);
    exe_squash_vld[1] = 1'b1; exe_squash_seq[1] = 8'd50; exe_mispred[1] = 1'b1;
    step();
    exe_squash_vld[1] = 1'b0; exe_mispred[1] = 1'b0;
    chk("R8 count two", int'(mispred_count), 2);
    chk("R5 t1 strobe", int'(sq_valid[1]), 1);
    chk("R5 t0 quiet", int'(sq_valid[0]), 0);
    exe_squash_vld[1] = 1'b1; exe_squash_seq[1] = 8'd40;
    dispatch_vld[1] = 1'b1; dispatch_seq[1] = 8'd60;
    step();
    exe_squash_vld[1] = 1'b0; dispatch_vld[1] = 1'b0;
    chk("R9 squash beats dispatch", int'(youngest_seq[1]), 40);
    chk("R8 count steady", int'(mispred_count), 2);
    finish_squash(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exe_accept();
    t_age_filter();
    t_trap();
    t_ctx();
    t_thread1();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule